// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block lets software run one serial-memory transaction at a time against an EEPROM on an SPI bus. Software sees two 64-bit registers: a control word, which carries an unlock key, a chip-select choice, a byte count, an opcode, a 24-bit memory address, a request bit and two status flags (done and nack); and a data word, which supplies the write payload or receives the read result.

The usual flow has two control writes. The first sets the configuration with request clear. The second writes the same value with request set. If the key is correct, the engine lowers the chosen chip select. It sends the opcode, then the three address bytes, then the data bytes, all most significant bit first, in SPI mode 0. After the last bit it raises the chip select and sets done. If the key is wrong, the engine never touches the bus and sets nack at once. Software polls the control word until one of the two flags is set.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset both registers read as zero, both chip selects are high and the serial clock is low.
- R2: A request with a key other than 9 (key in control bits [63:60], request in bit 56) sets nack (bit 58) on the clock edge that takes the write. It asserts no chip select, leaves done (bit 57) clear, and the request bit reads 0.
- R3: Control bit 59 picks the chip select. A 1 drives spi_cs_n[1] low and a 0 drives spi_cs_n[0] low, while the other stays high. Only one can be low at a time, and the serial clock stays low whenever both are high.
- R4: On the wire the engine sends the 8-bit opcode from bits [31:24], then the 24-bit address from bits [23:0], then the data. Every item goes most significant bit first. MOSI changes only on falling SCLK edges and MISO is sampled on rising edges.
- R5: Any opcode other than 0x03 is a write. It sends N×8 bits of the data register, starting at bit 63 and going down.
- R6: Opcode 0x03 is a read. Before the transfer the data register is cleared. The N received bytes then end up right-justified in it, with the first byte received in the most significant position of the result and all bits above it zero.
- R7: The byte count N comes from bits [34:32]. The values 1 to 7 are literal and 0 means eight bytes.
- R8: Done rises exactly (2·(32+8N)+1)·HALF_DIV clock cycles after the edge that accepts the request. On that same edge the chip select is released.
- R9: The request bit reads 1 while a transaction runs and clears itself when it ends. While busy, writes to either register are ignored.
- R10: Accepting a new request clears done and nack. Written values of the status bits never change them, and a control write with request clear updates only the configuration fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 data word |
| wr_data | input | 64 | Write value |
| ctrl_rd | output | 64 | Current control word with status |
| data_rd | output | 64 | Current data word |
| spi_cs_n | output | 2 | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
Status results have fixed latencies after the write that carries the request:
- A refused request shows nack one edge after that write, so the bench samples at the falling edge that follows it.
- An accepted request shows its chip select and the busy request bit at that same falling edge.
- Done is due (2·(32+8N)+1)·HALF_DIV edges after acceptance. The bench counts that many rising edges and checks that done is still low one cycle before and high exactly at that edge, for both a 3-byte and an 8-byte transfer.

Wire order and byte placement are checked through a behavioural memory model in the bench. That model captures the opcode and address and stores or returns data bytes in mode-0 timing.

// File: rtl/see_pkg.sv
package see_pkg;
    localparam int REG_W     = 64;
    localparam int HDR_W     = 32;
    localparam int TX_W      = HDR_W + REG_W;
    localparam int BIT_CNT_W = $clog2(TX_W + 1);

    // control word field positions (bit 63 is the most significant)
    localparam int KEY_HI   = 63;
    localparam int KEY_LO   = 60;
    localparam int CSSEL_B  = 59;
    localparam int NACK_B   = 58;
    localparam int DONE_B   = 57;
    localparam int REQ_B    = 56;
    localparam int CNT_HI   = 34;
    localparam int CNT_LO   = 32;
    localparam int OP_HI    = 31;
    localparam int OP_LO    = 24;
    localparam int ADDR_HI  = 23;

    localparam logic [7:0] OPC_READ = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        eng_state_e       st;
        logic [3:0]       key;
        logic             cs_sel;
        logic [2:0]       cnt;
        logic [7:0]       op;
        logic [23:0]      addr;
        logic             done;
        logic             nack;
        logic [REG_W-1:0] data;
    } eng_regs_t;

    // total bits on the wire: header plus payload, count 0 meaning eight bytes
    function automatic logic [BIT_CNT_W-1:0] frame_bits(input logic [2:0] cnt);
        logic [3:0] nbytes;
        nbytes = (cnt == 3'd0) ? 4'd8 : {1'b0, cnt};
        return BIT_CNT_W'(HDR_W) + {nbytes, 3'b000};
    endfunction
endpackage

// File: rtl/see_tick.sv
module see_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q + 1'b1;
        if (!en || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/see_serdes.sv
module see_serdes
    import see_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [TX_W-1:0]      load_frame,
    input  logic [BIT_CNT_W-1:0] load_bits,
    input  logic                 run,
    input  logic                 tick,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 rx_valid,
    output logic                 rx_bit,
    output logic                 last
);
    typedef struct packed {
        logic [TX_W-1:0]      tx;
        logic [BIT_CNT_W-1:0] sent;
        logic [BIT_CNT_W-1:0] total;
        logic                 ph;
    } ser_t;

    ser_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        rise = run && tick && !s_q.ph;
        fall = run && tick && s_q.ph;
        s_d  = s_q;
        if (load) begin
            s_d.tx    = load_frame;
            s_d.sent  = '0;
            s_d.total = load_bits;
            s_d.ph    = 1'b0;
        end else if (rise) begin
            s_d.ph = 1'b1;
        end else if (fall) begin
            s_d.ph   = 1'b0;
            s_d.tx   = {s_q.tx[TX_W-2:0], 1'b0};
            s_d.sent = s_q.sent + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk     = s_q.ph;
    assign mosi     = s_q.tx[TX_W-1];
    assign rx_valid = rise && (s_q.sent >= BIT_CNT_W'(HDR_W));
    assign rx_bit   = miso;
    assign last     = fall && (s_q.sent == s_q.total - 1'b1);
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import see_pkg::*;
#(
    parameter int         HALF_DIV   = 2,
    parameter logic [3:0] UNLOCK_KEY = 4'h9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [REG_W-1:0] data_rd,
    output logic [1:0]       spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int CS_N = 2;

    eng_regs_t r_d, r_q;
    logic busy, run, tick, load, rx_valid, rx_bit, last;
    logic [TX_W-1:0] load_frame;
    logic [BIT_CNT_W-1:0] load_bits;

    assign busy = (r_q.st != ST_IDLE);
    assign run  = (r_q.st == ST_SHIFT);

    see_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    always_comb begin
        r_d        = r_q;
        load       = 1'b0;
        load_bits  = frame_bits(wr_data[CNT_HI:CNT_LO]);
        load_frame = {wr_data[OP_HI:0],
                      (wr_data[OP_HI:OP_LO] == OPC_READ) ? {REG_W{1'b0}} : r_q.data};

        if (wr_en && !busy) begin
            if (!wr_sel) begin
                r_d.key    = wr_data[KEY_HI:KEY_LO];
                r_d.cs_sel = wr_data[CSSEL_B];
                r_d.cnt    = wr_data[CNT_HI:CNT_LO];
                r_d.op     = wr_data[OP_HI:OP_LO];
                r_d.addr   = wr_data[ADDR_HI:0];
                if (wr_data[REQ_B]) begin
                    r_d.done = 1'b0;
                    if (wr_data[KEY_HI:KEY_LO] == UNLOCK_KEY) begin
                        r_d.nack = 1'b0;
                        r_d.st   = ST_SHIFT;
                        load     = 1'b1;
                        if (wr_data[OP_HI:OP_LO] == OPC_READ) begin
                            r_d.data = '0;
                        end
                    end else begin
                        r_d.nack = 1'b1;
                    end
                end
            end else begin
                r_d.data = wr_data;
            end
        end

        if (run) begin
            if (rx_valid && r_q.op == OPC_READ) begin
                r_d.data = {r_q.data[REG_W-2:0], rx_bit};
            end
            if (last) begin
                r_d.st = ST_FINISH;
            end
        end

        if (r_q.st == ST_FINISH && tick) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    see_serdes u_serdes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_frame(load_frame),
        .load_bits (load_bits),
        .run       (run),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit),
        .last      (last)
    );

    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign spi_cs_n[g] = !(busy && (r_q.cs_sel == g[0]));
    end

    assign ctrl_rd = {r_q.key, r_q.cs_sel, r_q.nack, r_q.done, busy,
                      21'b0, r_q.cnt, r_q.op, r_q.addr};
    assign data_rd = r_q.data;
endmodule

// File: rtl/see_checker.sv
module see_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       nack,
    input logic       done,
    input logic       req
);
    p_nack_no_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> (cs_n == 2'b11));

    p_cs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_idle_sclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 2'b11) |-> !sclk);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cs_n == 2'b11) && !sclk);

    p_busy_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != 2'b11) |-> req);

    p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && nack));
endmodule

bind spi_eeprom_engine see_checker u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (spi_cs_n),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .nack (ctrl_rd[58]),
    .done (ctrl_rd[57]),
    .req  (ctrl_rd[56])
);

// File: tb/tb_spi_eeprom_engine.sv
`timescale 1ns/1ps
module tb_spi_eeprom_engine;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] ctrl_rd, data_rd;
    logic [1:0] spi_cs_n;
    logic spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [256];
    logic [7:0]  cap_op;
    logic [23:0] cap_ad;
    logic [7:0]  sh;
    int          bitn = 0;
    logic        saw_cs0, saw_cs1;
    logic        cs_all;

    always #5 clk = ~clk;

    spi_eeprom_engine #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ctrl_rd(ctrl_rd), .data_rd(data_rd),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    assign cs_all = &spi_cs_n;

    // behavioural memory, mode 0
    always @(posedge spi_sclk or negedge cs_all) begin
        if (!cs_all && !spi_sclk) begin
            bitn = 0;
        end else if (!cs_all) begin
            if (bitn < 8) cap_op = {cap_op[6:0], spi_mosi};
            else if (bitn < 32) cap_ad = {cap_ad[22:0], spi_mosi};
            else begin
                sh = {sh[6:0], spi_mosi};
                if (((bitn - 32) % 8) == 7 && cap_op != 8'h03)
                    mem[8'(cap_ad[7:0] + 8'((bitn - 32) / 8))] = sh;
            end
            bitn = bitn + 1;
        end
    end

    always @(negedge spi_sclk) begin
        if (!cs_all && bitn >= 32 && cap_op == 8'h03)
            spi_miso = mem[8'(cap_ad[7:0] + 8'((bitn - 32) / 8))][7 - ((bitn - 32) % 8)];
    end

    always @(negedge clk) begin
        if (!spi_cs_n[0]) saw_cs0 = 1'b1;
        if (!spi_cs_n[1]) saw_cs1 = 1'b1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [3:0] key, input logic sel,
                                       input logic [2:0] cnt, input logic [7:0] op,
                                       input logic [23:0] addr, input logic req);
        logic [63:0] w;
        w = '0;
        w[63:60] = key; w[59] = sel; w[56] = req;
        w[34:32] = cnt; w[31:24] = op; w[23:0] = addr;
        return w;
    endfunction

    task automatic wr(input logic sel, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_end(input string tag);
        int n;
        n = 0;
        while (!(ctrl_rd[57] || ctrl_rd[58]) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, 64'(n < 4000), 64'd1);
    endtask

    // exact done timing from the accepting edge
    task automatic check_timing(input int nbytes, input string tag);
        int due;
        due = (2 * (32 + 8 * nbytes) + 1) * HALF;
        repeat (due - 1) @(posedge clk);
        @(negedge clk);
        chk({tag, " done not early"}, 64'(ctrl_rd[57]), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " done on time"}, 64'(ctrl_rd[57]), 64'd1);
        chk({tag, " cs released"}, 64'(spi_cs_n), 64'd3);
    endtask

    task automatic t_reset();
        chk("R1 ctrl", ctrl_rd, 64'd0);
        chk("R1 data", data_rd, 64'd0);
        chk("R1 cs", 64'(spi_cs_n), 64'd3);
        chk("R1 sclk", 64'(spi_sclk), 64'd0);
    endtask

    task automatic t_bad_key();
        wr(1'b0, mk(4'h5, 1'b0, 3'd3, 8'h03, 24'h10, 1'b1));
        chk("R2 nack", 64'(ctrl_rd[58]), 64'd1);
        chk("R2 done", 64'(ctrl_rd[57]), 64'd0);
        chk("R2 req", 64'(ctrl_rd[56]), 64'd0);
        chk("R2 cs", 64'(spi_cs_n), 64'd3);
        repeat (4) @(negedge clk);
        chk("R2 cs later", 64'(spi_cs_n), 64'd3);
    endtask

    task automatic t_read3();
        logic [63:0] exp;
        exp = {40'd0, mem[8'h10], mem[8'h11], mem[8'h12]};
        wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(1'b0, mk(4'h9, 1'b0, 3'd3, 8'h03, 24'h000010, 1'b0));
        chk("R10 config write keeps nack", 64'(ctrl_rd[58]), 64'd1);
        wr(1'b0, mk(4'h9, 1'b0, 3'd3, 8'h03, 24'h000010, 1'b1));
        chk("R3 cs0 low", 64'(spi_cs_n), 64'd2);
        chk("R9 req busy", 64'(ctrl_rd[56]), 64'd1);
        chk("R10 nack cleared", 64'(ctrl_rd[58]), 64'd0);
        check_timing(3, "R8 3 bytes");
        chk("R9 req cleared", 64'(ctrl_rd[56]), 64'd0);
        chk("R6 read data", data_rd, exp);
        chk("R4 opcode", 64'(cap_op), 64'h03);
        chk("R4 address", 64'(cap_ad), 64'h10);
    endtask

    task automatic t_write2_cs1();
        logic [7:0] keep;
        keep = mem[8'h42];
        saw_cs0 = 1'b0; saw_cs1 = 1'b0;
        wr(1'b1, 64'hA1B2_C3D4_E5F6_0718);
        wr(1'b0, mk(4'h9, 1'b1, 3'd2, 8'h02, 24'h000040, 1'b0));
        wr(1'b0, mk(4'h9, 1'b1, 3'd2, 8'h02, 24'h000040, 1'b1));
        wait_end("R5 write finishes");
        chk("R3 cs1 used", 64'(saw_cs1), 64'd1);
        chk("R3 cs0 unused", 64'(saw_cs0), 64'd0);
        chk("R5 byte0", 64'(mem[8'h40]), 64'hA1);
        chk("R5 byte1", 64'(mem[8'h41]), 64'hB2);
        chk("R5 byte2 untouched", 64'(mem[8'h42]), 64'(keep));
        chk("R4 write opcode", 64'(cap_op), 64'h02);
    endtask

    task automatic t_eight();
        wr(1'b1, 64'h0123_4567_89AB_CDEF);
        wr(1'b0, mk(4'h9, 1'b0, 3'd0, 8'h02, 24'h000080, 1'b1));
        check_timing(8, "R8 R7 8 bytes");
        chk("R7 mem first", 64'(mem[8'h80]), 64'h01);
        chk("R7 mem last", 64'(mem[8'h87]), 64'hEF);
        wr(1'b0, mk(4'h9, 1'b0, 3'd0, 8'h03, 24'h000080, 1'b1));
        wait_end("R7 read finishes");
        chk("R7 read all 8", data_rd, 64'h0123_4567_89AB_CDEF);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] keep;
        keep = mem[8'h30];
        wr(1'b1, 64'h7700_0000_0000_0055);
        wr(1'b0, mk(4'h9, 1'b0, 3'd1, 8'h02, 24'h000020, 1'b1));
        repeat (10) @(negedge clk);
        wr(1'b0, mk(4'h9, 1'b1, 3'd1, 8'h02, 24'h000030, 1'b1));
        wr(1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
        wait_end("R9 busy run ends");
        chk("R9 addr kept", 64'(ctrl_rd[23:0]), 64'h20);
        chk("R9 sel kept", 64'(ctrl_rd[59]), 64'd0);
        chk("R9 data kept", data_rd, 64'h7700_0000_0000_0055);
        chk("R9 target written", 64'(mem[8'h20]), 64'h77);
        chk("R9 other untouched", 64'(mem[8'h30]), 64'(keep));
    endtask

    task automatic t_status_bits();
        logic [63:0] w;
        w = mk(4'h9, 1'b0, 3'd1, 8'h02, 24'h000020, 1'b0);
        w[58] = 1'b1; w[57] = 1'b0;
        wr(1'b0, w);
        chk("R10 nack write ignored", 64'(ctrl_rd[58]), 64'd0);
        chk("R10 done write ignored", 64'(ctrl_rd[57]), 64'd1);
        wr(1'b0, mk(4'h3, 1'b0, 3'd1, 8'h02, 24'h000020, 1'b1));
        chk("R10 done cleared on request", 64'(ctrl_rd[57]), 64'd0);
        chk("R2 nack after done", 64'(ctrl_rd[58]), 64'd1);
    endtask

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bad_key();
        t_read3();
        t_write2_cs1();
        t_eight();
        t_busy_ignore();
        t_status_bits();
        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule